// File: doc/BRIEF.md
# Master Clock Ratio Detector

This block works out how many master-clock cycles fit into one frame-clock period of a digital audio stream. It rounds that number to one of seven legal ratios (128, 192, 256, 384, 512, 768 or 1152 times the sample rate). From the ratio it derives the speed band for the converter core and the factor by which the master clock must be divided to make the internal modulator clock. The master clock has to be frequency-locked to the frame clock, but their phase relation can be anything. The block therefore samples the frame clock into the master-clock domain and times only its rising edges.

A mode-select input chooses between two schemes. In automatic setting, the ratio also sets the speed band: the two lowest ratios mean quad speed, 256 and 384 mean double speed, and the three highest mean normal speed. In manual setting the band is always normal, and the ratio only sets the divider. The block accepts a ratio only when two periods in a row round to the same value. It drops its valid flag as soon as a period disagrees, falls outside every tolerance window, or the frame clock stops.

Top module: `mclk_ratio_detect`

## Requirements
- R1: While reset is held, and in the first cycles after it is released, `ratio_valid` is 0 and `ratio_code`, `speed_mode` and `div_code` are all 0.
- R2: A frame period of N master-clock cycles is accepted as ratio R when |N - R| <= 2. The ratio codes are 0=128, 1=192, 2=256, 3=384, 4=512, 5=768 and 6=1152. A period 3 or more cycles from every legal ratio is never accepted.
- R3: After reset, the first frame-clock rising edge only starts the count. The edge that ends the first measured period proposes a candidate. `ratio_valid` rises only after the edge that ends a second consecutive period rounding to the same ratio.
- R4: When a measured period rounds to a different ratio from the one accepted, or to no ratio at all, `ratio_valid` drops before the new ratio can be accepted.
- R5: If no frame-clock rising edge arrives for 1155 master-clock cycles, the counter saturates and `ratio_valid` is 0 from the next cycle on.
- R6: With `auto_sel` = 0 (manual), `speed_mode` is 0 (normal) whenever the ratio is valid. Ratios 128 and 192 are not valid in manual setting.
- R7: With `auto_sel` = 1 (automatic), `speed_mode` is 2 (quad) for ratios 128 and 192, 1 (double) for 256 and 384, and 0 (normal) for 512, 768 and 1152.
- R8: `div_code` gives the master-clock divide factor: 0 = /1, 1 = /1.5, 2 = /2, 3 = /3, 4 = /4.5. Ratios 128 and 256 give 0, 192 and 384 give 1, 512 gives 2, 768 gives 3 and 1152 gives 4. The modulator clock is therefore 128 fs in the quad band and 256 fs in the other bands.
- R9: Whenever `ratio_valid` is 0, `ratio_code`, `speed_mode` and `div_code` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; every register of the block runs on it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lrck | input | 1 | Frame clock, one period per sample, any phase to `mclk` |
| auto_sel | input | 1 | 1 = automatic setting, 0 = manual setting |
| ratio_code | output | 3 | Accepted ratio code (see R2), 0 when not valid |
| speed_mode | output | 2 | 0 normal, 1 double, 2 quad |
| div_code | output | 3 | Internal master-clock divide code (see R8) |
| ratio_valid | output | 1 | A legal ratio has been confirmed for the current setting |

## Verification
The bench sweeps every legal ratio with frame periods at the exact ratio, at both edges of the ±2 window, and 3 cycles outside it. This separates rounding to the nearest ratio from rejecting a period that is out of tolerance. Each locked point is read in both setting modes, so the speed band and manual rejection of the quad-band ratios are told apart from the divide mapping. Separate patterns cover the other cases. A start from reset is sampled between the second and third edge to show the two-period rule. A switch to another ratio shows that the flag falls before the new ratio locks. A stopped frame clock exercises saturation.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

  localparam int NUM_RATIOS = 7;

  typedef enum logic [1:0] {
    SPD_NORMAL = 2'd0,
    SPD_DOUBLE = 2'd1,
    SPD_QUAD   = 2'd2
  } speed_e;

  typedef enum logic [2:0] {
    DIV_1   = 3'd0,
    DIV_1P5 = 3'd1,
    DIV_2   = 3'd2,
    DIV_3   = 3'd3,
    DIV_4P5 = 3'd4
  } div_e;

  // Master-clock cycles per frame for each ratio code.
  function automatic int ratio_of(input int idx);
    case (idx)
      0:       return 128;
      1:       return 192;
      2:       return 256;
      3:       return 384;
      4:       return 512;
      5:       return 768;
      default: return 1152;
    endcase
  endfunction

endpackage

// File: rtl/mcr_rst_sync.sv
module mcr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_ns = chain_q[STAGES-1];
endmodule

// File: rtl/mcr_sync.sv
module mcr_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/mcr_period_counter.sv
module mcr_period_counter #(
  parameter int CNT_W   = 11,
  parameter int CNT_MAX = 1155
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_s,
  output logic             meas_stb,
  output logic [CNT_W-1:0] meas_cnt,
  output logic             sat
);
  localparam logic [CNT_W-1:0] MAXV = CNT_W'(CNT_MAX);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic             frame_d_q;
  logic             armed_q, armed_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             rise;
  logic             cnt_en;

  always_comb begin
    rise    = frame_s & ~frame_d_q;
    sat     = (cnt_q == MAXV);
    cnt_en  = rise | ~sat;
    armed_n = armed_q | rise;
    cnt_n   = rise ? ONE : cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_d_q <= 1'b0;
      armed_q   <= 1'b0;
    end else begin
      frame_d_q <= frame_s;
      armed_q   <= armed_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  // The count held on a rising edge is the length of the period just ended.
  assign meas_stb = rise & armed_q;
  assign meas_cnt = cnt_q;
endmodule

// File: rtl/mcr_classifier.sv
module mcr_classifier
  import mcr_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int TOL   = 2
) (
  input  logic [CNT_W-1:0] meas_cnt,
  output logic             hit_any,
  output logic [2:0]       hit_code
);
  logic [NUM_RATIOS-1:0] hit;

  for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_win
    localparam logic [CNT_W-1:0] LO = CNT_W'(ratio_of(i) - TOL);
    localparam logic [CNT_W-1:0] HI = CNT_W'(ratio_of(i) + TOL);
    assign hit[i] = (meas_cnt >= LO) && (meas_cnt <= HI);
  end

  always_comb begin
    hit_code = 3'd0;
    for (int i = 0; i < NUM_RATIOS; i++) begin
      if (hit[i]) hit_code = 3'(i);
    end
    hit_any = |hit;
  end
endmodule

// File: rtl/mcr_lock.sv
module mcr_lock (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       meas_stb,
  input  logic       hit_any,
  input  logic [2:0] hit_code,
  input  logic       sat,
  output logic       locked,
  output logic [2:0] ratio_q
);
  logic       lock_q, lock_n;
  logic       cand_ok_q, cand_ok_n;
  logic [2:0] cand_q, cand_n;
  logic [2:0] ratio_n;
  logic       upd_en;

  always_comb begin
    lock_n    = lock_q;
    cand_ok_n = cand_ok_q;
    cand_n    = cand_q;
    ratio_n   = ratio_q;
    upd_en    = sat | meas_stb;
    if (sat) begin
      lock_n    = 1'b0;
      cand_ok_n = 1'b0;
    end else if (meas_stb) begin
      if (!hit_any) begin
        lock_n    = 1'b0;
        cand_ok_n = 1'b0;
      end else if (cand_ok_q && (hit_code == cand_q)) begin
        lock_n  = 1'b1;
        ratio_n = hit_code;
      end else begin
        lock_n    = 1'b0;
        cand_n    = hit_code;
        cand_ok_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q    <= 1'b0;
      cand_ok_q <= 1'b0;
      cand_q    <= 3'd0;
      ratio_q   <= 3'd0;
    end else if (upd_en) begin
      lock_q    <= lock_n;
      cand_ok_q <= cand_ok_n;
      cand_q    <= cand_n;
      ratio_q   <= ratio_n;
    end
  end

  assign locked = lock_q;
endmodule

// File: rtl/mcr_mode_map.sv
module mcr_mode_map
  import mcr_pkg::*;
(
  input  logic       locked,
  input  logic [2:0] ratio_q,
  input  logic       auto_s,
  output logic       valid,
  output logic [2:0] code_o,
  output logic [1:0] speed_o,
  output logic [2:0] div_o
);
  speed_e spd;
  div_e   dv;

  always_comb begin
    valid = locked & (auto_s | (ratio_q >= 3'd2));

    if (!auto_s)               spd = SPD_NORMAL;
    else if (ratio_q < 3'd2)   spd = SPD_QUAD;
    else if (ratio_q < 3'd4)   spd = SPD_DOUBLE;
    else                       spd = SPD_NORMAL;

    case (ratio_q)
      3'd0, 3'd2: dv = DIV_1;
      3'd1, 3'd3: dv = DIV_1P5;
      3'd4:       dv = DIV_2;
      3'd5:       dv = DIV_3;
      default:    dv = DIV_4P5;
    endcase

    code_o  = valid ? ratio_q : 3'd0;
    speed_o = valid ? spd     : SPD_NORMAL;
    div_o   = valid ? dv      : DIV_1;
  end
endmodule

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect
  import mcr_pkg::*;
#(
  parameter int TOL         = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       mclk,
  input  logic       rst_n,
  input  logic       lrck,
  input  logic       auto_sel,
  output logic [2:0] ratio_code,
  output logic [1:0] speed_mode,
  output logic [2:0] div_code,
  output logic       ratio_valid
);
  localparam int CNT_MAX = ratio_of(NUM_RATIOS - 1) + TOL + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic             rst_ns;
  logic [1:0]       sync_q;
  logic             frame_s, auto_s;
  logic             meas_stb, sat;
  logic [CNT_W-1:0] meas_cnt;
  logic             hit_any;
  logic [2:0]       hit_code;
  logic             locked;
  logic [2:0]       ratio_q;

  mcr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(mclk), .rst_n(rst_n), .rst_ns(rst_ns)
  );

  mcr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(mclk), .rst_n(rst_ns), .d({auto_sel, lrck}), .q(sync_q)
  );
  assign frame_s = sync_q[0];
  assign auto_s  = sync_q[1];

  mcr_period_counter #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) u_cnt (
    .clk(mclk), .rst_n(rst_ns), .frame_s(frame_s),
    .meas_stb(meas_stb), .meas_cnt(meas_cnt), .sat(sat)
  );

  mcr_classifier #(.CNT_W(CNT_W), .TOL(TOL)) u_cls (
    .meas_cnt(meas_cnt), .hit_any(hit_any), .hit_code(hit_code)
  );

  mcr_lock u_lock (
    .clk(mclk), .rst_n(rst_ns), .meas_stb(meas_stb), .hit_any(hit_any),
    .hit_code(hit_code), .sat(sat), .locked(locked), .ratio_q(ratio_q)
  );

  mcr_mode_map u_map (
    .locked(locked), .ratio_q(ratio_q), .auto_s(auto_s),
    .valid(ratio_valid), .code_o(ratio_code), .speed_o(speed_mode),
    .div_o(div_code)
  );
endmodule

// File: rtl/mcr_checker.sv
module mcr_checker (
  input logic       clk,
  input logic       rst_ns,
  input logic       auto_s,
  input logic       sat,
  input logic       meas_stb,
  input logic       hit_any,
  input logic [2:0] ratio_code,
  input logic [1:0] speed_mode,
  input logic [2:0] div_code,
  input logic       ratio_valid
);
  a_r6_manual_normal: assert property (@(posedge clk) disable iff (!rst_ns)
    (ratio_valid && !auto_s) |-> (speed_mode == 2'd0 && ratio_code >= 3'd2));

  a_r7_quad_band: assert property (@(posedge clk) disable iff (!rst_ns)
    (ratio_valid && auto_s && ratio_code < 3'd2) |-> (speed_mode == 2'd2));

  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_ns)
    !ratio_valid |-> (ratio_code == 3'd0 && speed_mode == 2'd0 && div_code == 3'd0));

  a_r5_sat_drop: assert property (@(posedge clk) disable iff (!rst_ns)
    sat |=> !ratio_valid);

  a_r4_miss_drop: assert property (@(posedge clk) disable iff (!rst_ns)
    (meas_stb && !hit_any) |=> !ratio_valid);

  a_r2_code_range: assert property (@(posedge clk) disable iff (!rst_ns)
    ratio_valid |-> (ratio_code <= 3'd6 && div_code <= 3'd4));
endmodule

bind mclk_ratio_detect mcr_checker u_chk (
  .clk(mclk), .rst_ns(rst_ns), .auto_s(auto_s), .sat(sat),
  .meas_stb(meas_stb), .hit_any(hit_any), .ratio_code(ratio_code),
  .speed_mode(speed_mode), .div_code(div_code), .ratio_valid(ratio_valid)
);

// File: tb/mclk_ratio_detect_test.sv
`timescale 1ns/1ps
module mclk_ratio_detect_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lrck = 1'b0;
  logic       auto_sel = 1'b1;
  logic [2:0] ratio_code;
  logic [1:0] speed_mode;
  logic [2:0] div_code;
  logic       ratio_valid;

  int  total = 0;
  int  failed = 0;
  int  per = 0;
  int  ph = 0;
  bit  restart = 0;
  bit  watch = 0;
  bit  saw_low = 0;
  bit  done = 0;

  always #2 clk = ~clk;

  mclk_ratio_detect uut (
    .mclk(clk), .rst_n(rst_n), .lrck(lrck), .auto_sel(auto_sel),
    .ratio_code(ratio_code), .speed_mode(speed_mode),
    .div_code(div_code), .ratio_valid(ratio_valid)
  );

  // Frame-clock generator, updated on the falling edge.
  always @(negedge clk) begin
    if (restart) begin ph = 0; restart = 0; end
    if (per == 0) begin
      lrck = 1'b0; ph = 0;
    end else begin
      lrck = (ph < per / 2);
      ph = (ph + 1 >= per) ? 0 : ph + 1;
    end
    if (watch && !ratio_valid) saw_low = 1;
  end

  function automatic int ratio_tab(int idx);
    int base;
    if (idx == 6) return 1152;
    base = (idx % 2 == 0) ? 128 : 192;
    return base << (idx / 2);
  endfunction

  task automatic check(string tag, bit ok, string got, string exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: got %s expected %s", tag, got, exp);
    end
  endtask

  task automatic set_period(int p);
    per = p; restart = 1;
  endtask

  task automatic expect_point(string tag, int idx, int off, bit am);
    int r, tgt, q2, ev, ec, es, ed;
    r  = ratio_tab(idx);
    ev = ((off <= 2) && (off >= -2) && (am || r >= 256)) ? 1 : 0;
    tgt = (am && r < 256) ? 128 : 256;
    q2 = 2 * r / tgt;
    ed = (q2 == 2) ? 0 : (q2 == 3) ? 1 : (q2 == 4) ? 2 : (q2 == 6) ? 3 : 4;
    es = !am ? 0 : (r >= 512) ? 0 : (r >= 256) ? 1 : 2;
    ec = idx;
    if (!ev) begin ec = 0; es = 0; ed = 0; end
    check(tag,
      ratio_valid == ev[0] && ratio_code == ec[2:0] && speed_mode == es[1:0] && div_code == ed[2:0],
      $sformatf("v=%0d code=%0d spd=%0d div=%0d", ratio_valid, ratio_code, speed_mode, div_code),
      $sformatf("v=%0d code=%0d spd=%0d div=%0d (ratio %0d off %0d auto %0d)", ev, ec, es, ed, r, off, am));
  endtask

  task automatic settle(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : main
    int offs[5] = '{-3, -2, 0, 2, 3};
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R1: outputs during reset
    check("R1 in reset", ratio_valid == 0 && ratio_code == 0 && speed_mode == 0 && div_code == 0,
          $sformatf("v=%0d c=%0d", ratio_valid, ratio_code), "all 0");
    rst_n = 1'b1;
    settle(4);
    check("R1 after release", ratio_valid == 0 && ratio_code == 0,
          $sformatf("v=%0d c=%0d", ratio_valid, ratio_code), "v=0 c=0");

    // R3: lock only after two matching periods
    @(posedge clk);
    set_period(256);
    settle(256 + 128);
    check("R3 one period", ratio_valid == 0, $sformatf("%0d", ratio_valid), "0");
    settle(256);
    check("R3 two periods", ratio_valid == 1 && ratio_code == 3'd2,
          $sformatf("v=%0d c=%0d", ratio_valid, ratio_code), "v=1 c=2");

    // R4: switching ratio drops valid before relock
    saw_low = 0; watch = 1;
    set_period(384);
    settle(4 * 384 + 12);
    watch = 0;
    check("R4 drop on mismatch", saw_low == 1, $sformatf("%0d", saw_low), "1");
    expect_point("R4 relock", 3, 0, 1);

    // R5: stopped frame clock
    set_period(0);
    settle(1300);
    check("R5 saturation", ratio_valid == 0, $sformatf("%0d", ratio_valid), "0");

    // R2 R6 R7 R8 R9 sweep
    for (int idx = 0; idx < 7; idx++) begin
      for (int k = 0; k < 5; k++) begin
        int p;
        p = ratio_tab(idx) + offs[k];
        auto_sel = 1'b1;
        set_period(p);
        settle(4 * p + 12);
        expect_point("R2 R7 R8 R9 auto", idx, offs[k], 1);
        auto_sel = 1'b0;
        settle(8);
        expect_point("R6 R8 R9 manual", idx, offs[k], 0);
        auto_sel = 1'b1;
        settle(8);
      end
    end

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; failed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule